// File: doc/BRIEF.md
# Audio Serial Port Bit-Clock and Frame-Sync Generator

This block is the timing source of an audio serial port that acts as clock master. It divides the system clock down to a symmetric bit clock and, on the bit-clock grid, forms a periodic frame-sync pulse whose frame length and active length are each set in bit clocks. A second sync mode replaces the periodic pulse with a one-bit pulse issued on demand for each transmitted word. The serial data path, the data mover and slave operation sit elsewhere.

Software sets it up through a two-word register write port. One word holds the timing fields and the other holds the run bits, the sync polarity and the sync mode. The divider and the frame-sync stage start and stop independently. Alongside the bit clock, a one-cycle strobe marks each rising bit-clock edge, so downstream logic in the system clock domain can advance without sampling the bit clock itself.

Top module: `aud_srgen`

## Requirements
- R1: After reset, bclk, bclk_en and fsync are 0. The timing word holds divider 0, frame field 31 and width field 15. The control word holds 4'b1000, which selects periodic mode with both stages stopped and active-high sync.
- R2: While the divider runs, bclk has a period of 2*(D+1) system clocks, with D+1 high and D+1 low, where D is the 8-bit divider field (D = 255 gives 512). bclk_en is high for exactly the first high cycle of each bclk period.
- R3: When the divider run bit is 0, bclk stays low, no bclk_en pulse occurs and fsync stays at its inactive level, whatever the frame-sync run bit holds.
- R4: In periodic mode, a frame is P+1 bit clocks long, where P is the 12-bit frame field (P = 4095 gives 4096).
- R5: Within each frame, fsync is active for the first min(W+1, P+1) bit clocks, where W is the 8-bit width field. When W >= P, fsync stays active for the whole frame.
- R6: Polarity bit 0 makes fsync active high. Polarity bit 1 makes it active low, and its inactive level is then high.
- R7: While the frame-sync run bit is 0, fsync holds its inactive level and the bit clock keeps running. After the bit is set, the first bit clock whose bclk_en follows the write is the first bit of a full frame.
- R8: With the mode bit at 0, fsync is active for exactly one bit clock, the first one that starts after a tx_word_req pulse. Without a request it stays inactive.
- R9: When cfg_we is high, cfg_sel selects the target. With cfg_sel = 0, the timing word is written: divider in bits [7:0], width in [15:8], frame in [27:16]. With cfg_sel = 1, the control word is written: bit 0 runs the divider, bit 1 runs the frame-sync stage, bit 2 selects polarity, and bit 3 = 1 selects periodic mode.
- R10: With the reset timing values, enabling both stages gives a 32-bit-clock frame with 16 active bit clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the timing word, 1 selects the control word |
| cfg_wdata | input | 28 | Configuration write data |
| tx_word_req | input | 1 | Per-word sync request used in word mode |
| bclk | output | 1 | Bit clock |
| bclk_en | output | 1 | One-cycle strobe on each rising bit-clock edge |
| fsync | output | 1 | Frame sync, polarity applied |

## Verification
The bench aims at the edges of every field. These are a divider of 0, where bclk toggles every cycle and a design that mis-handles the reload would stall or double the period, and a divider of 255, where an 8-bit counter that wraps wrongly gives a 256-cycle bit clock. It checks a one-bit frame, a width equal to and larger than the frame, and the 4096-bit maximum frame. A wrong comparison there would leave a gap of inactive bits in the frame, and a truncated counter would shorten the frame. It also checks that the first bit after enabling sync starts a full pulse and not a fragment, and that word mode emits a pulse only after a request and for exactly one bit.

// File: rtl/aud_srgen_pkg.sv
package aud_srgen_pkg;

  typedef enum logic {
    SEL_TIMING = 1'b0,
    SEL_CTRL   = 1'b1
  } srg_sel_e;

  // Control word, bit 0 upward: gen_run, fs_run, fs_low, gen_mode
  typedef struct packed {
    logic gen_mode;   // 1: periodic frame sync, 0: per-word sync
    logic fs_low;     // 1: active-low sync
    logic fs_run;     // frame-sync stage enable
    logic gen_run;    // divider enable
  } srg_ctrl_t;

  localparam int CTRL_W = $bits(srg_ctrl_t);

  localparam srg_ctrl_t CTRL_RST = '{gen_mode: 1'b1, fs_low: 1'b0,
                                     fs_run: 1'b0, gen_run: 1'b0};

endpackage

// File: rtl/aud_srgen_cfg.sv
module aud_srgen_cfg
  import aud_srgen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int WID_W   = 8,
  parameter int PER_W   = 12,
  parameter int DEF_WID = 15,
  parameter int DEF_PER = 31
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic                         sel,
  input  logic [DIV_W+WID_W+PER_W-1:0] wdata,
  output logic [DIV_W-1:0]             div,
  output logic [WID_W-1:0]             wid,
  output logic [PER_W-1:0]             per,
  output srg_ctrl_t                    ctrl
);

  localparam int WID_LSB = DIV_W;
  localparam int PER_LSB = WID_LSB + WID_W;
  localparam logic [WID_W-1:0] WID_RST = WID_W'(DEF_WID);
  localparam logic [PER_W-1:0] PER_RST = PER_W'(DEF_PER);

  logic [DIV_W-1:0] div_q, div_d;
  logic [WID_W-1:0] wid_q, wid_d;
  logic [PER_W-1:0] per_q, per_d;
  srg_ctrl_t        ctrl_q, ctrl_d;
  logic             tim_wr, ctl_wr;

  always_comb begin
    tim_wr = we && (srg_sel_e'(sel) == SEL_TIMING);
    ctl_wr = we && (srg_sel_e'(sel) == SEL_CTRL);
    div_d  = div_q;
    wid_d  = wid_q;
    per_d  = per_q;
    ctrl_d = ctrl_q;
    if (tim_wr) begin
      div_d = wdata[DIV_W-1:0];
      wid_d = wdata[WID_LSB +: WID_W];
      per_d = wdata[PER_LSB +: PER_W];
    end
    if (ctl_wr) begin
      ctrl_d = srg_ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      wid_q  <= WID_RST;
      per_q  <= PER_RST;
      ctrl_q <= CTRL_RST;
    end else begin
      if (tim_wr) begin
        div_q <= div_d;
        wid_q <= wid_d;
        per_q <= per_d;
      end
      if (ctl_wr) begin
        ctrl_q <= ctrl_d;
      end
    end
  end

  assign div  = div_q;
  assign wid  = wid_q;
  assign per  = per_q;
  assign ctrl = ctrl_q;

endmodule

// File: rtl/aud_srgen_div.sv
module aud_srgen_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bclk,
  output logic             bclk_en,
  output logic             bit_tick
);

  localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             bclk_q, bclk_d;
  logic             en_q, en_d;
  logic             half_tick;

  always_comb begin
    half_tick = run && (cnt_q == '0);
    bit_tick  = half_tick && !bclk_q;
    cnt_d     = cnt_q;
    bclk_d    = bclk_q;
    en_d      = 1'b0;
    if (!run) begin
      cnt_d  = div;
      bclk_d = 1'b0;
    end else if (half_tick) begin
      cnt_d  = div;
      bclk_d = !bclk_q;
      en_d   = bit_tick;
    end else begin
      cnt_d  = cnt_q - ONE_D;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
      en_q   <= en_d;
    end
  end

  assign bclk    = bclk_q;
  assign bclk_en = en_q;

endmodule

// File: rtl/aud_srgen_fsync.sv
module aud_srgen_fsync #(
  parameter int PER_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gen_mode,
  input  logic             bit_tick,
  input  logic             word_req,
  input  logic [PER_W-1:0] per,
  input  logic [WID_W-1:0] wid,
  output logic             act
);

  localparam int CMP_W = (PER_W > WID_W) ? PER_W : WID_W;
  localparam logic [PER_W-1:0] ONE_P = PER_W'(1);

  logic [PER_W-1:0] pcnt_q, pcnt_d, cur, pos;
  logic [CMP_W-1:0] pos_x, wid_x;
  logic             started_q, started_d;
  logic             act_q, act_d;
  logic             pend_q, pend_d;
  logic             gen_act;

  // Down-counter position within the frame; pos counts bits since frame start
  always_comb begin
    cur     = (!started_q || (pcnt_q == '0)) ? per : (pcnt_q - ONE_P);
    pos     = per - cur;
    pos_x   = CMP_W'(pos);
    wid_x   = CMP_W'(wid);
    gen_act = (pos_x <= wid_x);
  end

  always_comb begin
    pcnt_d    = pcnt_q;
    started_d = started_q;
    act_d     = act_q;
    pend_d    = pend_q;
    if (!en) begin
      pcnt_d    = per;
      started_d = 1'b0;
      act_d     = 1'b0;
      pend_d    = 1'b0;
    end else if (gen_mode) begin
      pend_d = 1'b0;
      if (bit_tick) begin
        pcnt_d    = cur;
        started_d = 1'b1;
        act_d     = gen_act;
      end
    end else begin
      started_d = 1'b0;
      pend_d    = pend_q || word_req;
      if (bit_tick) begin
        act_d  = pend_q || word_req;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q    <= '0;
      started_q <= 1'b0;
      act_q     <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      pcnt_q    <= pcnt_d;
      started_q <= started_d;
      act_q     <= act_d;
      pend_q    <= pend_d;
    end
  end

  assign act = act_q;

endmodule

// File: rtl/aud_srgen.sv
module aud_srgen
  import aud_srgen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int WID_W   = 8,
  parameter int PER_W   = 12,
  parameter int DEF_WID = 15,
  parameter int DEF_PER = 31
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic                         cfg_sel,
  input  logic [DIV_W+WID_W+PER_W-1:0] cfg_wdata,
  input  logic                         tx_word_req,
  output logic                         bclk,
  output logic                         bclk_en,
  output logic                         fsync
);

  logic [DIV_W-1:0] div_v;
  logic [WID_W-1:0] wid_v;
  logic [PER_W-1:0] per_v;
  srg_ctrl_t        ctrl_v;
  logic             bit_tick;
  logic             fs_act;
  logic             gen_run_w, fs_run_w, fs_low_w, fs_en_w;

  aud_srgen_cfg #(
    .DIV_W(DIV_W), .WID_W(WID_W), .PER_W(PER_W),
    .DEF_WID(DEF_WID), .DEF_PER(DEF_PER)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .div(div_v), .wid(wid_v), .per(per_v), .ctrl(ctrl_v)
  );

  assign gen_run_w = ctrl_v.gen_run;
  assign fs_run_w  = ctrl_v.fs_run;
  assign fs_low_w  = ctrl_v.fs_low;
  assign fs_en_w   = gen_run_w && fs_run_w;

  aud_srgen_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(gen_run_w), .div(div_v),
    .bclk(bclk), .bclk_en(bclk_en), .bit_tick(bit_tick)
  );

  aud_srgen_fsync #(.PER_W(PER_W), .WID_W(WID_W)) u_fs (
    .clk(clk), .rst_n(rst_n), .en(fs_en_w), .gen_mode(ctrl_v.gen_mode),
    .bit_tick(bit_tick), .word_req(tx_word_req), .per(per_v), .wid(wid_v),
    .act(fs_act)
  );

  assign fsync = fs_act ^ fs_low_w;

endmodule

// File: rtl/aud_srgen_chk.sv
module aud_srgen_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic bclk_en,
  input logic fsync,
  input logic gen_run,
  input logic fs_run,
  input logic fs_low
);

  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_en |=> !bclk_en) else $error("bclk_en wider than one cycle"); // R2

  AST_EN_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_en |-> (bclk && !$past(bclk))) else $error("bclk_en off rising edge"); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_run |=> (!bclk && !bclk_en)) else $error("bit clock while stopped"); // R3

  AST_FS_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_run && fs_run) |=> (fsync == fs_low)) else $error("sync active while stopped"); // R7

  AST_FS_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fsync) && $stable(fs_low) && $past(gen_run && fs_run)) |-> bclk_en)
    else $error("sync moved off a bit boundary"); // R4

endmodule

bind aud_srgen aud_srgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .bclk_en(bclk_en), .fsync(fsync),
  .gen_run(gen_run_w), .fs_run(fs_run_w), .fs_low(fs_low_w)
);

// File: tb/aud_srgen_tb.sv
`timescale 1ns/1ps
module aud_srgen_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_sel;
  logic [27:0] cfg_wdata;
  logic        tx_word_req;
  logic        bclk, bclk_en, fsync;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  aud_srgen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tx_word_req(tx_word_req),
    .bclk(bclk), .bclk_en(bclk_en), .fsync(fsync)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {div[28:21], per[20:9], wid[8:1], pol[0]}
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {8'd0,   12'd31,   8'd15, 1'b0},
    {8'd2,   12'd7,    8'd0,  1'b0},
    {8'd1,   12'd5,    8'd2,  1'b1},
    {8'd3,   12'd3,    8'd3,  1'b0},
    {8'd0,   12'd4,    8'd9,  1'b1},
    {8'd4,   12'd0,    8'd0,  1'b0},
    {8'd255, 12'd1,    8'd0,  1'b1},
    {8'd0,   12'd4095, 8'd7,  1'b0}
  };

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [27:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_en();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (bclk_en) return;
    end
  endtask

  // Called at a negedge showing bclk_en; measures one bit-clock period
  task automatic measure(input int d, input string req);
    int per_c = 0, hi_c = 0;
    for (int k = 0; k < 2000; k++) begin
      per_c++;
      if (bclk) hi_c++;
      @(negedge clk);
      if (bclk_en) break;
    end
    chk(per_c == 2*(d+1), {req, " bclk period"}, per_c, 2*(d+1));
    chk(hi_c == d+1, {req, " bclk high time"}, hi_c, d+1);
  endtask

  // Samples fsync at the next nbits bclk_en pulses, bit 0 = frame start
  task automatic frame(input int p, input int w, input bit pol, input int nbits,
                       input string req);
    int bad = 0, first_bad = -1;
    bit exp_l;
    for (int i = 0; i < nbits; i++) begin
      wait_en();
      exp_l = (((i % (p+1)) <= w) ? 1'b1 : 1'b0) ^ pol;
      if (fsync !== exp_l) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    if (bad != 0) $display("  first mismatching bit index %0d", first_bad);
    chk(bad == 0, {req, " fsync pattern mismatches"}, bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    int d, p, w;
    bit pol;
    int bad;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = '0; tx_word_req = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset outputs
    chk(bclk == 0, "R1 bclk after reset", bclk, 0);
    chk(bclk_en == 0, "R1 bclk_en after reset", bclk_en, 0);
    chk(fsync == 0, "R1 fsync after reset", fsync, 0);

    // R10 / R1: reset timing values, periodic mode bit 3 set
    wr(1'b1, 28'hB);
    frame(31, 15, 1'b0, 64, "R10 R1 default frame");
    wait_en();
    measure(0, "R1 R2 default divider");

    // Table walk: R2 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      d   = int'(VEC[v][28:21]);
      p   = int'(VEC[v][20:9]);
      w   = int'(VEC[v][8:1]);
      pol = VEC[v][0];
      wr(1'b1, 28'(8 + 4*pol));
      wr(1'b0, {VEC[v][20:9], VEC[v][8:1], VEC[v][28:21]});
      wr(1'b1, 28'(8 + 4*pol + 1));
      wait_en();
      measure(d, $sformatf("R2 R9 vec%0d", v));
      bad = 0;
      for (int i = 0; i < 3; i++) begin
        wait_en();
        if (fsync !== pol) bad++;
      end
      chk(bad == 0, $sformatf("R7 R6 vec%0d sync idle level", v), bad, 0);
      wr(1'b1, 28'(8 + 4*pol + 3));
      frame(p, w, pol, 2*(p+1), $sformatf("R4 R5 R6 R7 R9 vec%0d", v));
    end

    // R3: divider stopped, sync stage enabled
    wr(1'b1, 28'hA);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bclk || bclk_en || fsync) bad++;
    end
    chk(bad == 0, "R3 outputs quiet with divider stopped", bad, 0);

    // R8: word mode
    wr(1'b0, {12'd31, 8'd15, 8'd3});
    wr(1'b1, 28'h3);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      wait_en();
      if (fsync) bad++;
    end
    chk(bad == 0, "R8 no sync without request", bad, 0);
    tx_word_req = 1'b1;
    @(negedge clk);
    tx_word_req = 1'b0;
    wait_en();
    chk(fsync == 1, "R8 sync on first bit after request", fsync, 1);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      wait_en();
      if (fsync) bad++;
    end
    chk(bad == 0, "R8 sync lasts one bit", bad, 0);

    done = 1;
    report();
    $finish;
  end

endmodule